// File: doc/BRIEF.md
# Microcontroller Interrupt Unit

This block is the interrupt unit of a small 4-bit microcontroller core. It gathers three request sources into three request flags. The first source is an external pin that triggers on an edge toward a programmable level. The second is a free-running timer-1 prescaler. The third is a timer-2 event pulse supplied from outside the block.

The core drives strobes into the block: enable, disable, instruction boundary and flag test. It also drives two blocking inputs, one for a pending skip and one for an inhibiting previous instruction. When interrupts are enabled and the boundary is clean, the block picks the highest-priority eligible flag. It then issues a one-clock take pulse together with a vector address. It holds a forced-no-op window for one machine cycle and saves the core's subroutine-mode bit into a one-deep shadow.

The core uses the take pulse to push its PC and to clear its subroutine-mode bit. A software test of timer flag 1 or 2 returns the flag as a skip request and clears it.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset, `flags` is 0, `int_en` is 0, `take`, `force_nop` and `skip_req` are 0, the timer enables are 0 and the pin polarity is 1 (rising edge).
- R2: Flag bit 0 (external) sets when the synchronized pin changes and its new level equals the polarity bit. The polarity bit is written through `pol_wr`/`pol_val`. A pin change made before clock edge k shows in `flags[0]` after edge k+2.
- R3: Timer 1 sets flag bit 1 every CYC_CLKS*2^PRE_BITS clocks. The prescaler restarts at reset, so the first set lands on the edge of that number after reset release.
- R4: No interrupt is taken while `int_en` is 0. `ei_stb` sets `int_en` and `di_stb` clears it.
- R5: An interrupt is accepted only on a clock where `boundary` is 1. It is refused when `skip_pending` or `inhibit` is 1, on the first boundary after an `ei_stb` or `di_stb`, and while `force_nop` is 1.
- R6: Fixed priority: flag 0 wins whenever set. Next comes flag 1 if timer-enable bit 0 (`v_data[0]`) is set, then flag 2 if timer-enable bit 1 (`v_data[1]`) is set. Flag 0 has no enable.
- R7: Taking interrupt n pulses `take` for one clock and sets `vector` = INT_PAGE*128 + 2*n. It clears `int_en` and flag n, and copies `sub_mode` into `sm_shadow`.
- R8: `force_nop` is 1 for exactly CYC_CLKS clocks starting with the `take` clock.
- R9: `test1`/`test2` make `skip_req` equal, one clock later, to the value flag 1 or flag 2 had when the test was sampled. The tested flag is cleared.
- R10: When a flag set and a clear of the same flag meet on one clock, the flag ends up set.
- R11: `t2_tick` sets flag bit 2, and `v_wr` loads the two timer-enable bits from `v_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| pol_wr | input | 1 | Load the pin polarity bit |
| pol_val | input | 1 | New polarity (1 = rising edge) |
| v_wr | input | 1 | Load the timer-enable bits |
| v_data | input | 2 | Bit 0 timer-1 enable, bit 1 timer-2 enable |
| t2_tick | input | 1 | Timer-2 event, sets flag 2 |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| boundary | input | 1 | Instruction boundary |
| skip_pending | input | 1 | Core has a skip pending |
| inhibit | input | 1 | Previous instruction blocks acceptance |
| test1 | input | 1 | Test-and-clear flag 1 |
| test2 | input | 1 | Test-and-clear flag 2 |
| sub_mode | input | 1 | Core subroutine-mode bit |
| take | output | 1 | Interrupt taken pulse |
| vector | output | PAGE_W+7 | Interrupt vector address |
| force_nop | output | 1 | Forced no-op window |
| sm_shadow | output | 1 | Saved subroutine-mode bit |
| skip_req | output | 1 | Skip result of a flag test |
| int_en | output | 1 | Global interrupt enable |
| flags | output | 3 | Request flags: external, timer 1, timer 2 |

## Verification
The bench builds the unit with CYC_CLKS=2, PRE_BITS=3 and INT_PAGE=5. With these values the timer-1 flag fires every 16 clocks, so the first and second timer periods fit inside short scenarios, and every vector has a distinct nonzero page. This makes a full sweep feasible: all eight flag patterns are crossed with all four enable patterns, each from a fresh reset, with the winner and vector computed arithmetically. Both polarities are swept against both pin edges, and test-and-clear is made to collide with timer-1 and timer-2 sets.

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl #(
  parameter int CYC_CLKS = 6,
  parameter int PRE_BITS = 7,
  parameter int PAGE_W   = 4,
  parameter int INT_PAGE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              pol_wr,
  input  logic              pol_val,
  input  logic              v_wr,
  input  logic [1:0]        v_data,
  input  logic              t2_tick,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              boundary,
  input  logic              skip_pending,
  input  logic              inhibit,
  input  logic              test1,
  input  logic              test2,
  input  logic              sub_mode,
  output logic              take,
  output logic [PAGE_W+6:0] vector,
  output logic              force_nop,
  output logic              sm_shadow,
  output logic              skip_req,
  output logic              int_en,
  output logic [2:0]        flags
);
  localparam int VEC_W = PAGE_W + 7;
  localparam int DIV_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam int NOP_W = $clog2(CYC_CLKS + 1);
  localparam logic [PAGE_W-1:0] PAGE_V = PAGE_W'(INT_PAGE);

  logic                s1, s2, prev, pol;
  logic [1:0]          t_en;
  logic [DIV_W-1:0]    div;
  logic [PRE_BITS-1:0] pre;
  logic                hold;
  logic [NOP_W-1:0]    nop_cnt;
  logic [1:0]          win;

  wire ext_set = (s2 != prev) && (s2 == pol);
  wire div_end = (div == DIV_W'(CYC_CLKS - 1));
  wire t1_set  = div_end && (&pre);

  wire       gate = boundary && int_en && !skip_pending && !inhibit && !hold
                    && !ei_stb && !di_stb && (nop_cnt == '0);
  wire [2:0] elig = {flags[2] & t_en[1], flags[1] & t_en[0], flags[0]};
  wire       fire = gate && (|elig);

  always_comb begin
    if (elig[0])      win = 2'd0;
    else if (elig[1]) win = 2'd1;
    else              win = 2'd2;
  end

  wire [2:0] won  = fire ? (3'b001 << win) : 3'b000;
  wire [2:0] sets = {t2_tick, t1_set, ext_set};
  wire [2:0] clrs = {test2, test1, 1'b0} | won;

  assign force_nop = (nop_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0; pol <= 1'b1;
    end else begin
      s1 <= ext_pin;
      s2 <= s1;
      prev <= s2;
      if (pol_wr) pol <= pol_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0; pre <= '0;
    end else begin
      div <= div_end ? '0 : div + 1'b1;
      if (div_end) pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0; t_en <= '0; skip_req <= 1'b0;
    end else begin
      flags <= (flags & ~clrs) | sets;
      if (v_wr) t_en <= v_data;
      skip_req <= test1 ? flags[1] : (test2 ? flags[2] : 1'b0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en <= 1'b0; hold <= 1'b0; take <= 1'b0;
      vector <= '0; nop_cnt <= '0; sm_shadow <= 1'b0;
    end else begin
      if (fire)        int_en <= 1'b0;
      else if (di_stb) int_en <= 1'b0;
      else if (ei_stb) int_en <= 1'b1;
      if (ei_stb || di_stb) hold <= 1'b1;
      else if (boundary)    hold <= 1'b0;
      take <= fire;
      if (fire) begin
        vector    <= {PAGE_V, 4'b0000, win, 1'b0};
        sm_shadow <= sub_mode;
        nop_cnt   <= NOP_W'(CYC_CLKS);
      end else if (nop_cnt != '0) begin
        nop_cnt <= nop_cnt - 1'b1;
      end
    end
  end

  p_take_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(int_en));
  p_take_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary && !skip_pending && !inhibit));
  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!int_en && vector[VEC_W-1:7] == PAGE_V));
  p_nop_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> force_nop);
  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vector[2:1] != 2'd0) |-> !$past(flags[0]));
  p_ext_pol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(s2 == pol));
  p_skip_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test1 |=> (skip_req == $past(flags[1])));
  p_test_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (test2 && !t2_tick) |=> !flags[2]);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    t2_tick |=> flags[2]);
endmodule

// File: tb/mcu_irq_ctrl_bench.sv
module mcu_irq_ctrl_bench;
  localparam int VW = 11;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_pin = 0, pol_wr = 0, pol_val = 0, v_wr = 0, t2_tick = 0;
  logic [1:0] v_data = 0;
  logic ei_stb = 0, di_stb = 0, boundary = 0, skip_pending = 0, inhibit = 0;
  logic test1 = 0, test2 = 0, sub_mode = 0;
  logic take, force_nop, sm_shadow, skip_req, int_en;
  logic [VW-1:0] vector;
  logic [2:0] flags;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mcu_irq_ctrl #(.CYC_CLKS(2), .PRE_BITS(3), .PAGE_W(4), .INT_PAGE(5)) u_mcu_irq_ctrl (
    .clk, .rst_n, .ext_pin, .pol_wr, .pol_val, .v_wr, .v_data, .t2_tick,
    .ei_stb, .di_stb, .boundary, .skip_pending, .inhibit, .test1, .test2,
    .sub_mode, .take, .vector, .force_nop, .sm_shadow, .skip_req, .int_en, .flags);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {ext_pin, pol_wr, pol_val, v_wr, t2_tick, ei_stb, di_stb} = '0;
    {boundary, skip_pending, inhibit, test1, test2, sub_mode} = '0;
    v_data = 0;
    go(2);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    chk("R1 flags", flags, 0);
    chk("R1 int_en", int_en, 0);
    chk("R1 take/nop/skip", {take, force_nop, skip_req}, 0);

    // R2: polarity sweep
    for (int p = 0; p < 2; p++) begin
      do_reset();
      if (p == 0) begin pol_wr = 1; pol_val = 0; go(1); pol_wr = 0; end
      ext_pin = 1; go(2);
      chk("R2 latency", flags[0], 0);
      go(1);
      chk("R2 rising edge vs polarity", flags[0], p);
      go(1);
      ext_pin = 0; go(3);
      chk("R2 falling edge vs polarity", flags[0], 1);
    end

    // R4 R7 R8
    do_reset();
    sub_mode = 1; ext_pin = 1; go(3);
    boundary = 1; go(1); boundary = 0;
    chk("R4 no take while disabled", take, 0);
    ei_stb = 1; go(1); ei_stb = 0;
    chk("R4 ei sets enable", int_en, 1);
    boundary = 1; go(1);
    chk("R5 first boundary after ei refused", take, 0);
    go(1); boundary = 0;
    chk("R7 take", take, 1);
    chk("R7 vector", vector, 640);
    chk("R7 enable cleared", int_en, 0);
    chk("R7 flag cleared", flags[0], 0);
    chk("R7 shadow", sm_shadow, 1);
    chk("R8 nop clk1", force_nop, 1);
    go(1);
    chk("R7 single pulse", take, 0);
    chk("R8 nop clk2", force_nop, 1);
    go(1);
    chk("R8 nop end", force_nop, 0);

    // R5 blockers
    do_reset();
    ext_pin = 1; go(3);
    ei_stb = 1; go(1); ei_stb = 0;
    boundary = 1; go(1);
    skip_pending = 1; go(1); skip_pending = 0;
    chk("R5 skip blocks", take, 0);
    inhibit = 1; go(1); inhibit = 0;
    chk("R5 inhibit blocks", take, 0);
    boundary = 0; go(1);
    chk("R5 no boundary", take, 0);
    boundary = 1; go(1); boundary = 0;
    chk("R5 clean boundary accepts", take, 1);

    do_reset();
    ext_pin = 1; go(3);
    ei_stb = 1; go(1); ei_stb = 0;
    di_stb = 1; go(1); di_stb = 0;
    chk("R4 di clears enable", int_en, 0);
    boundary = 1; go(2); boundary = 0;
    chk("R4 no take after di", take, 0);
    chk("R4 flag kept", flags[0], 1);

    // R6 R11 R3: full priority sweep
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 4; e++) begin
        int w;
        int expf;
        do_reset();
        v_wr = 1; v_data = e[1:0]; t2_tick = f[2]; go(1);
        v_wr = 0; t2_tick = 0;
        if (f[0]) ext_pin = 1;
        go(15);
        if (!f[1]) begin test1 = 1; go(1); test1 = 0; end
        else go(1);
        chk("R11 R3 flags before", flags, f);
        ei_stb = 1; go(1); ei_stb = 0;
        boundary = 1; go(2); boundary = 0;
        w = f[0] ? 0 : (f[1] && e[0]) ? 1 : (f[2] && e[1]) ? 2 : -1;
        chk("R6 take", take, (w >= 0) ? 1 : 0);
        expf = f;
        if (w >= 0) begin
          chk("R6 vector", vector, 640 + 2 * w);
          expf = f & ~(1 << w);
        end
        chk("R7 flags after", flags, expf);
      end
    end

    // R9 R10 R3
    do_reset();
    t2_tick = 1; go(1); t2_tick = 0;
    chk("R11 t2 sets", flags[2], 1);
    test2 = 1; go(1); test2 = 0;
    chk("R9 skip from flag2", skip_req, 1);
    chk("R9 flag2 cleared", flags[2], 0);
    test2 = 1; go(1);
    chk("R9 skip zero", skip_req, 0);
    t2_tick = 1; go(1); t2_tick = 0; test2 = 0;
    chk("R10 set wins flag2", flags[2], 1);
    go(11);
    chk("R3 before period", flags[1], 0);
    test1 = 1; go(1);
    chk("R10 set wins flag1", flags[1], 1);
    chk("R9 old flag1", skip_req, 0);
    go(1); test1 = 0;
    chk("R9 skip flag1", skip_req, 1);
    chk("R9 flag1 cleared", flags[1], 0);
    go(14);
    chk("R3 second period early", flags[1], 0);
    go(1);
    chk("R3 second period", flags[1], 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule